// File: doc/BRIEF.md
# Shared-Cache Line Transaction Tracker with Atomic Ordering

This block sits between the request side and the memory side of a shared second-level cache. It holds one entry for each cache line that has work in flight. Each entry counts outstanding non-atomic requests and outstanding atomics separately. For every request sent downstream, the block also keeps a record in a slot table, indexed by the ID that travels with the request. When a response comes back carrying that ID, the block routes it to the compute unit named in that request's own record, and returns the bypass flags from the same record. A later request to the same line therefore never overwrites the record of an earlier one.

Non-atomic requests go to the issue port in the cycle they are accepted. Atomics first enter a small per-line queue. An atomic leaves that queue only once the line has no outstanding non-atomic request. A line's entry is released once its two counters and its queue are all empty. When a new line cannot get an entry, a needed resource is missing, or ordering would be broken, the block refuses the upstream request by holding its ready low.

Top module: `l2_pend_tracker`

## Requirements
- R1: After reset no line is tracked. `iss_valid` is low, and `req_ready` is high for a non-atomic request.
- R2: An accepted non-atomic request is presented on the issue port in the same cycle: `iss_atomic`=0, with the request's line and bypass bits, and an `iss_id` that no outstanding request holds. When `iss_ready` is low, a non-atomic request is refused.
- R3: An atomic is accepted into its line's queue and is not issued while any non-atomic request to that line is outstanding. It is offered on the issue port with `iss_atomic`=1 in the cycle after the line's last non-atomic response.
- R4: A response with ID k reports on `done_*` the compute unit, bypass bits, line and kind recorded when ID k was issued, whatever later requests to that line have carried.
- R5: A non-atomic response reports `done_atomic`=0 and leaves the line's atomic count unchanged, so the line stays tracked while its atomic is outstanding.
- R6: A line's entry is released, and becomes available to another line, once its non-atomic count, atomic count and queued atomics are all zero.
- R7: A request whose line matches no entry is refused while every entry is in use.
- R8: A non-atomic request to a line that has queued atomics is refused.
- R9: An atomic to a line whose queue already holds two atomics is refused.
- R10: A non-atomic request is refused while every ID is outstanding.
- R11: A queued atomic that is ready to issue takes the issue port ahead of an upstream non-atomic request, which is refused in that cycle.
- R12: The queued atomics of one line issue in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Upstream request accepted this cycle |
| req_line | input | LINE_W | Line address of the request |
| req_atomic | input | 1 | Request is an atomic |
| req_cu | input | CU_W | Requesting compute unit |
| req_bypass | input | BYP_W | Cache-bypass flags of the request |
| iss_valid | output | 1 | Downstream issue present |
| iss_ready | input | 1 | Downstream accepts the issue |
| iss_id | output | ID_W | Transaction ID of the issued request |
| iss_line | output | LINE_W | Line of the issued request |
| iss_atomic | output | 1 | Issued request is an atomic |
| iss_bypass | output | BYP_W | Bypass flags of the issued request |
| rsp_valid | input | 1 | Downstream response present |
| rsp_id | input | ID_W | ID of the returning request |
| done_valid | output | 1 | Completion toward the requester |
| done_cu | output | CU_W | Compute unit that receives the completion |
| done_bypass | output | BYP_W | Bypass flags of the completed request |
| done_line | output | LINE_W | Line of the completed request |
| done_atomic | output | 1 | Completed request was an atomic |

## Verification
If a line's counter is wrong, the fault shows up at the ports in one of two ways. A released atomic can appear on the issue port in the cycle after a response while a load is still outstanding. Or a line can keep its entry too long, in which case a request to a fresh line is refused when it should be accepted. Both effects appear within one cycle of the faulty response. A shared or overwritten per-request record shows up as a completion whose compute unit or bypass bits differ from the ones issued with that ID. The bench therefore checks every completion against its own table of issued IDs.

// File: rtl/pt_pkg.sv
package pt_pkg;

  // next value of an up/down occupancy counter
  function automatic logic [31:0] step_count(input logic [31:0] cur, input logic inc,
                                             input logic dec);
    return cur + {31'd0, inc} - {31'd0, dec};
  endfunction

  // position in a shift queue where a pushed item lands
  function automatic logic [31:0] push_slot(input logic [31:0] fill, input logic pop);
    return fill - {31'd0, pop};
  endfunction

endpackage

// File: rtl/pt_lowest.sv
module pt_lowest #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pt_slot_table.sv
module pt_slot_table #(
  parameter int NSLOT = 8,
  parameter int REC_W = 8,
  localparam int ID_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [REC_W-1:0] wr_rec,
  input  logic             clr,
  input  logic [ID_W-1:0]  clr_id,
  output logic [NSLOT-1:0] busy,
  output logic [REC_W-1:0] rd_rec
);
  logic [REC_W-1:0] rec_q [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      if (clr) busy[clr_id] <= 1'b0;
      if (wr)  busy[wr_id]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) rec_q[wr_id] <= wr_rec;
  end

  assign rd_rec = rec_q[clr_id];
endmodule

// File: rtl/pt_line_entry.sv
module pt_line_entry #(
  parameter int LINE_W = 16,
  parameter int HREC_W = 6,
  parameter int HDEPTH = 2,
  parameter int CNT_W  = 4,
  localparam int HC_W  = $clog2(HDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic              push,
  input  logic [HREC_W-1:0] push_rec,
  input  logic              pop,
  input  logic              inc_na,
  input  logic              dec_na,
  input  logic              dec_at,
  output logic              valid,
  output logic [LINE_W-1:0] line,
  output logic [CNT_W-1:0]  cnt_na,
  output logic [CNT_W-1:0]  cnt_at,
  output logic [HC_W-1:0]   held,
  output logic [HREC_W-1:0] head_rec
);
  logic [HREC_W-1:0] q_mem [HDEPTH];
  logic [CNT_W-1:0]  na_nx, at_nx;
  logic [HC_W-1:0]   held_nx, wr_pos;
  logic              live_nx;

  always_comb begin
    na_nx   = CNT_W'(pt_pkg::step_count(32'(cnt_na), inc_na, dec_na));
    at_nx   = CNT_W'(pt_pkg::step_count(32'(cnt_at), pop, dec_at));
    held_nx = HC_W'(pt_pkg::step_count(32'(held), push, pop));
    wr_pos  = HC_W'(pt_pkg::push_slot(32'(held), pop));
    live_nx = (valid | alloc) && ((na_nx != '0) || (at_nx != '0) || (held_nx != '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      line   <= '0;
      cnt_na <= '0;
      cnt_at <= '0;
      held   <= '0;
    end else begin
      valid  <= live_nx;
      cnt_na <= na_nx;
      cnt_at <= at_nx;
      held   <= held_nx;
      if (alloc) line <= alloc_line;
    end
  end

  // shift queue: head at position 0
  always_ff @(posedge clk) begin
    if (pop) begin
      for (int k = 0; k < HDEPTH - 1; k++) q_mem[k] <= q_mem[k+1];
    end
    if (push) q_mem[wr_pos] <= push_rec;
  end

  assign head_rec = q_mem[0];
endmodule

// File: rtl/l2_pend_tracker.sv
module l2_pend_tracker #(
  parameter int LINE_W = 16,
  parameter int CU_W   = 4,
  parameter int BYP_W  = 2,
  parameter int NENT   = 4,
  parameter int NSLOT  = 8,
  parameter int HDEPTH = 2,
  localparam int ID_W   = $clog2(NSLOT),
  localparam int EI_W   = $clog2(NENT),
  localparam int CNT_W  = $clog2(NSLOT + 1),
  localparam int HC_W   = $clog2(HDEPTH + 1),
  localparam int HREC_W = CU_W + BYP_W,
  localparam int REC_W  = LINE_W + CU_W + BYP_W + 1 + EI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_atomic,
  input  logic [CU_W-1:0]   req_cu,
  input  logic [BYP_W-1:0]  req_bypass,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ID_W-1:0]   iss_id,
  output logic [LINE_W-1:0] iss_line,
  output logic              iss_atomic,
  output logic [BYP_W-1:0]  iss_bypass,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  output logic              done_valid,
  output logic [CU_W-1:0]   done_cu,
  output logic [BYP_W-1:0]  done_bypass,
  output logic [LINE_W-1:0] done_line,
  output logic              done_atomic
);
  // per-entry state
  logic              ent_valid [NENT];
  logic [LINE_W-1:0] ent_line  [NENT];
  logic [CNT_W-1:0]  ent_na    [NENT];
  logic [CNT_W-1:0]  ent_at    [NENT];
  logic [HC_W-1:0]   ent_held  [NENT];
  logic [HREC_W-1:0] ent_head  [NENT];

  // flattened views for the checker
  logic [NENT-1:0]       ent_valid_v;
  logic [NENT*CNT_W-1:0] na_flat, at_flat;
  logic [NENT*HC_W-1:0]  held_flat;

  logic [NENT-1:0] hit_v, free_v, rel_v, dec_na_v, dec_at_v;
  logic            hit_any, free_any, rel_any;
  logic [EI_W-1:0] hit_idx, free_idx, rel_idx, tgt_ent;

  logic [NSLOT-1:0] busy;
  logic             slot_any;
  logic [ID_W-1:0]  slot_idx;

  logic ent_ok, rel_go, up_na_ok, up_at_ok;
  logic iss_fire, rel_fire, up_na_fire, up_at_fire;

  logic [REC_W-1:0]  wr_rec, rsp_rec;
  logic              rsp_atomic;
  logic [EI_W-1:0]   rsp_ent;
  logic [CU_W-1:0]   head_cu;
  logic [BYP_W-1:0]  head_byp;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      ent_valid_v[i] = ent_valid[i];
      hit_v[i]  = ent_valid[i] && (ent_line[i] == req_line);
      free_v[i] = !ent_valid[i];
      rel_v[i]  = ent_valid[i] && (ent_held[i] != '0) && (ent_na[i] == '0);
      na_flat[i*CNT_W +: CNT_W] = ent_na[i];
      at_flat[i*CNT_W +: CNT_W] = ent_at[i];
      held_flat[i*HC_W +: HC_W] = ent_held[i];
    end
  end

  pt_lowest #(.N(NENT))  i_hit  (.req(hit_v),  .any(hit_any),  .idx(hit_idx));
  pt_lowest #(.N(NENT))  i_free (.req(free_v), .any(free_any), .idx(free_idx));
  pt_lowest #(.N(NENT))  i_rel  (.req(rel_v),  .any(rel_any),  .idx(rel_idx));
  pt_lowest #(.N(NSLOT)) i_slot (.req(~busy),  .any(slot_any), .idx(slot_idx));

  always_comb begin
    tgt_ent  = hit_any ? hit_idx : free_idx;
    ent_ok   = hit_any | free_any;
    rel_go   = rel_any & slot_any;
    {head_cu, head_byp} = ent_head[rel_idx];
    up_na_ok = !req_atomic && ent_ok && slot_any && !rel_go &&
               (!hit_any || (ent_held[hit_idx] == '0));
    up_at_ok = req_atomic && ent_ok &&
               (!hit_any || (32'(ent_held[hit_idx]) < HDEPTH));
    req_ready = (up_na_ok & iss_ready) | up_at_ok;

    iss_valid  = rel_go | (req_valid & up_na_ok);
    iss_id     = slot_idx;
    iss_atomic = rel_go;
    iss_line   = rel_go ? ent_line[rel_idx] : req_line;
    iss_bypass = rel_go ? head_byp : req_bypass;

    iss_fire   = iss_valid & iss_ready;
    rel_fire   = iss_fire & rel_go;
    up_na_fire = iss_fire & !rel_go;
    up_at_fire = req_valid & up_at_ok;

    wr_rec = rel_go ? {ent_line[rel_idx], head_cu, head_byp, 1'b1, rel_idx}
                    : {req_line, req_cu, req_bypass, 1'b0, tgt_ent};
  end

  pt_slot_table #(.NSLOT(NSLOT), .REC_W(REC_W)) i_slots (
    .clk(clk), .rst_n(rst_n),
    .wr(iss_fire), .wr_id(slot_idx), .wr_rec(wr_rec),
    .clr(rsp_valid), .clr_id(rsp_id),
    .busy(busy), .rd_rec(rsp_rec)
  );

  assign {done_line, done_cu, done_bypass, rsp_atomic, rsp_ent} = rsp_rec;
  assign done_valid  = rsp_valid;
  assign done_atomic = rsp_atomic;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic alloc_g, push_g, pop_g, inc_g;
    always_comb begin
      alloc_g     = (up_na_fire | up_at_fire) && !hit_any && (free_idx == EI_W'(g));
      push_g      = up_at_fire && (tgt_ent == EI_W'(g));
      pop_g       = rel_fire && (rel_idx == EI_W'(g));
      inc_g       = up_na_fire && (tgt_ent == EI_W'(g));
      dec_na_v[g] = rsp_valid && !rsp_atomic && (rsp_ent == EI_W'(g));
      dec_at_v[g] = rsp_valid &&  rsp_atomic && (rsp_ent == EI_W'(g));
    end
    pt_line_entry #(.LINE_W(LINE_W), .HREC_W(HREC_W), .HDEPTH(HDEPTH), .CNT_W(CNT_W)) i_entry (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_g), .alloc_line(req_line),
      .push(push_g), .push_rec({req_cu, req_bypass}),
      .pop(pop_g), .inc_na(inc_g), .dec_na(dec_na_v[g]), .dec_at(dec_at_v[g]),
      .valid(ent_valid[g]), .line(ent_line[g]), .cnt_na(ent_na[g]), .cnt_at(ent_at[g]),
      .held(ent_held[g]), .head_rec(ent_head[g])
    );
  end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int NENT   = 4,
  parameter int NSLOT  = 8,
  parameter int HDEPTH = 2,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int HC_W  = $clog2(HDEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  hit_any,
  input logic [NENT-1:0]       ent_valid_v,
  input logic                  iss_valid,
  input logic                  iss_ready,
  input logic                  iss_atomic,
  input logic [NENT*CNT_W-1:0] na_flat,
  input logic [NENT*CNT_W-1:0] at_flat,
  input logic [NENT*HC_W-1:0]  held_flat,
  input logic [NSLOT-1:0]      busy,
  input logic                  rsp_valid,
  input logic                  rsp_atomic,
  input logic [NENT-1:0]       dec_at_v
);
  int outstanding;
  always_comb begin
    outstanding = 0;
    for (int i = 0; i < NENT; i++) begin
      outstanding += int'(na_flat[i*CNT_W +: CNT_W]) + int'(at_flat[i*CNT_W +: CNT_W]);
    end
  end

  p_count_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding == $countones(busy));

  p_load_keeps_atom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_atomic) |-> (dec_at_v == '0));

  p_full_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_any && (&ent_valid_v)) |-> !req_ready);

  p_release_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_atomic && !iss_ready) |=> (iss_valid && iss_atomic));

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    p_live_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid_v[g] |-> ((na_flat[g*CNT_W +: CNT_W] != '0) ||
                          (at_flat[g*CNT_W +: CNT_W] != '0) ||
                          (held_flat[g*HC_W +: HC_W] != '0)));
    p_held_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(held_flat[g*HC_W +: HC_W]) <= HDEPTH);
  end
endmodule

bind l2_pend_tracker pt_checker #(.NENT(NENT), .NSLOT(NSLOT), .HDEPTH(HDEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .hit_any(hit_any), .ent_valid_v(ent_valid_v), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_atomic(iss_atomic), .na_flat(na_flat), .at_flat(at_flat),
  .held_flat(held_flat), .busy(busy), .rsp_valid(rsp_valid), .rsp_atomic(rsp_atomic),
  .dec_at_v(dec_at_v)
);

// File: tb/test_l2_pend_tracker.sv
module test_l2_pend_tracker;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_atomic = 0, iss_ready = 1, rsp_valid = 0;
  logic [15:0] req_line = '0;
  logic [3:0]  req_cu = '0;
  logic [1:0]  req_bypass = '0;
  logic [2:0]  rsp_id = '0;
  logic        req_ready, iss_valid, iss_atomic, done_valid, done_atomic;
  logic [2:0]  iss_id;
  logic [15:0] iss_line, done_line;
  logic [1:0]  iss_bypass, done_bypass;
  logic [3:0]  done_cu;

  l2_pend_tracker i_l2_pend_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_atomic(req_atomic), .req_cu(req_cu), .req_bypass(req_bypass),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_id(iss_id), .iss_line(iss_line),
    .iss_atomic(iss_atomic), .iss_bypass(iss_bypass), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .done_valid(done_valid), .done_cu(done_cu), .done_bypass(done_bypass),
    .done_line(done_line), .done_atomic(done_atomic)
  );

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  // bench's own table of issued IDs
  logic        m_busy [8];
  logic [3:0]  m_cu   [8];
  logic [1:0]  m_byp  [8];
  logic [15:0] m_line [8];
  logic        m_atom [8];
  int last_id;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic record(input int id, input int line, input int cu, input int byp, input bit at);
    chk(!m_busy[id], "R2 fresh id", id, -1);
    m_busy[id] = 1; m_cu[id] = 4'(cu); m_byp[id] = 2'(byp);
    m_line[id] = 16'(line); m_atom[id] = at;
    last_id = id;
  endtask

  task automatic send_na(input int line, input int cu, input int byp, input bit exp_ok,
                         input string tag);
    req_valid = 1; req_atomic = 0; req_line = 16'(line); req_cu = 4'(cu); req_bypass = 2'(byp);
    #1;
    chk(req_ready == exp_ok, tag, req_ready, exp_ok);
    if (exp_ok) begin
      chk(iss_valid && !iss_atomic, "R2 issue kind", iss_atomic, 0);
      chk(iss_line == 16'(line), "R2 issue line", iss_line, line);
      chk(iss_bypass == 2'(byp), "R2 issue bypass", iss_bypass, byp);
      record(iss_id, line, cu, byp, 0);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_at(input int line, input int cu, input int byp, input bit exp_ok,
                         input string tag);
    req_valid = 1; req_atomic = 1; req_line = 16'(line); req_cu = 4'(cu); req_bypass = 2'(byp);
    #1;
    chk(req_ready == exp_ok, tag, req_ready, exp_ok);
    @(negedge clk);
    req_valid = 0; req_atomic = 0;
  endtask

  task automatic take_release(input int line, input int cu, input int byp, input string tag);
    #1;
    chk(iss_valid && iss_atomic, tag, iss_atomic, 1);
    chk(iss_line == 16'(line), tag, iss_line, line);
    chk(iss_bypass == 2'(byp), tag, iss_bypass, byp);
    record(iss_id, line, cu, byp, 1);
    @(negedge clk);
  endtask

  task automatic respond(input int id);
    rsp_valid = 1; rsp_id = 3'(id);
    #1;
    chk(done_valid, "R4 done valid", done_valid, 1);
    chk(done_cu == m_cu[id], "R4 done cu", done_cu, m_cu[id]);
    chk(done_bypass == m_byp[id], "R4 done bypass", done_bypass, m_byp[id]);
    chk(done_line == m_line[id], "R4 done line", done_line, m_line[id]);
    chk(done_atomic == m_atom[id], "R5 done kind", done_atomic, m_atom[id]);
    @(negedge clk);
    rsp_valid = 0; m_busy[id] = 0;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
      finish_up();
    end
  end

  initial begin
    int a, b, r1, r2, p, q;
    int ids [4];
    for (int i = 0; i < 8; i++) m_busy[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!iss_valid, "R1 idle issue", iss_valid, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    @(negedge clk);

    // R2: issue port back-pressure refuses non-atomics
    iss_ready = 0;
    req_valid = 1; req_line = 16'd9; #1;
    chk(!req_ready && iss_valid, "R2 stalled issue", req_ready, 0);
    @(negedge clk);
    req_valid = 0; iss_ready = 1;

    // R2/R4/R10: sweep all IDs over two lines with varied cu and bypass
    for (int i = 0; i < 8; i++) send_na(i % 2, i + 3, i % 4, 1, "R2 accept");
    send_na(0, 1, 1, 0, "R10 ids exhausted");
    for (int i = 7; i >= 0; i--) respond(i);

    // R3/R8/R9/R11/R12 on line 5
    send_na(5, 1, 0, 1, "R2 accept"); a = last_id;
    send_na(5, 2, 3, 1, "R2 accept"); b = last_id;
    send_at(5, 9, 1, 1, "R3 atomic queued");
    send_at(5, 10, 2, 1, "R3 atomic queued");
    send_at(5, 11, 3, 0, "R9 queue full");
    send_na(5, 12, 0, 0, "R8 load behind atomic");
    #1; chk(!iss_valid, "R3 atomic held", iss_valid, 0);
    respond(a);
    #1; chk(!iss_valid, "R3 still one load", iss_valid, 0);
    respond(b);
    req_valid = 1; req_atomic = 0; req_line = 16'd6; #1;
    chk(!req_ready, "R11 release has priority", req_ready, 0);
    req_valid = 0;
    take_release(5, 9, 1, "R3 release first"); r1 = last_id;
    take_release(5, 10, 2, "R12 release second"); r2 = last_id;
    #1; chk(!iss_valid, "R12 queue drained", iss_valid, 0);
    respond(r1);
    chk(m_cu[r1] == 4'd9, "R12 order", m_cu[r1], 9);
    respond(r2);

    // R5/R6/R7: fill every entry, one line holding an atomic and a load
    send_at(1, 3, 0, 1, "R3 atomic queued");
    take_release(1, 3, 0, "R3 immediate release"); q = last_id;
    send_na(1, 4, 1, 1, "R2 accept"); p = last_id;
    for (int i = 0; i < 3; i++) begin
      send_na(i + 2, i, 2, 1, "R6 fresh entry");
      ids[i] = last_id;
    end
    send_na(7, 5, 0, 0, "R7 table full");
    respond(p);
    send_na(7, 5, 0, 0, "R5 atomic keeps entry");
    respond(q);
    send_na(7, 5, 0, 1, "R6 entry released");
    ids[3] = last_id;
    for (int i = 0; i < 4; i++) respond(ids[i]);
    #1; chk(!iss_valid, "R1 idle end", iss_valid, 0);
    finish_up();
  end
endmodule